// File: doc/BRIEF.md
# Dual-Channel Phase-Count PWM Generator

This block produces two independent pulse-width-modulated outputs. Each channel takes one of several tick-enable sources from the surrounding clock tree, slows it with its own programmable prescaler, and then alternates between a high phase and a low phase. The length of each phase is a count of prescaled ticks, so the waveform is set directly by a high count and a low count instead of a period and a compare threshold.

Software programs the block through a small synchronous register bus. One shared control word carries, for every channel, the tick-source select, the prescaler divide value, a clock gate and an output gate. Each channel also has its own duty word holding its two phase counts. A channel runs only while both of its gates are set. Clearing the output gate stops the waveform at once. Setting it again restarts the waveform cleanly from the start of a high phase.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset both outputs are low and the control word and both duty words read back as zero.
- R2: Address 0 selects the control word, address 1 the duty word of channel A and address 2 the duty word of channel B. A read returns the last value written. Address 3 reads zero and writes to it change nothing.
- R3: In the control word, channel c owns bits starting at 16*c: divider in bits [6:0], source select in bits [8:7], clock gate in bit 9, output gate in bit 10. All other bits are not stored and read as zero.
- R4: A duty word holds the high count in bits [31:16] and the low count in bits [15:0]. A running channel is high for that many prescaled ticks, then low for that many, so one period is high+low ticks.
- R5: The prescaled tick fires once every divider+1 pulses of the selected source. A divider of 0 passes every source pulse through.
- R6: The source select value s makes the channel count pulses of src_tick[s] only.
- R7: A low count of 0 with a non-zero high count holds the output constantly high.
- R8: A high count of 0 holds the output constantly low, whatever the low count.
- R9: A channel whose clock gate or output gate is clear drives its output low.
- R10: The output follows a gate change in the first cycle after the write. Disabling cuts the current period short. Enabling starts a high phase from a zero count with a cleared prescaler.
- R11: A duty word written while the channel runs takes effect at the next phase boundary. The phase in progress completes with the old count.
- R12: The two channels run independently, each with its own source, divider and counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | One-cycle tick-enable pulses of the selectable sources |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 2 | Waveform outputs, bit 0 channel A, bit 1 channel B |

## Verification
A phase counter or shadow count that goes wrong shows as a high or low run on pwm_out that is the wrong length. That is visible within one period, (high+low)*(divider+1) cycles after the fault. A prescaler fault stretches or shrinks every phase by a whole multiple of ticks, so a bench that compares pwm_out every cycle against the expected pattern sees it within the first phase. Faults in gating or restart show in the first cycle after the control write. A lost or misplaced register field shows at once on bus_rdata.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
   // bit distance between the per-channel slices of the control word
   localparam int CH_STRIDE = 16;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   // number of control bits one channel uses: divider, select, two gates
   function automatic int ctrl_fld_w(input int div_w, input int sel_w);
      return div_w + sel_w + 2;
   endfunction

   // mask of the control bits that are actually stored
   function automatic logic [31:0] ctrl_mask(input int nch, input int fld_w);
      logic [31:0] m;
      m = '0;
      for (int c = 0; c < nch; c++) begin
         for (int b = 0; b < fld_w; b++) begin
            m[c*CH_STRIDE + b] = 1'b1;
         end
      end
      return m;
   endfunction
endpackage

// File: rtl/dpwm_regs.sv
`timescale 1ns/1ps
module dpwm_regs
   import dpwm_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 7,
   parameter int SEL_W  = 2,
   parameter int ADDR_W = 2
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic                             bus_we,
   input  logic [DATA_W-1:0]                bus_wdata,
   output logic [DATA_W-1:0]                bus_rdata,
   output logic [NUM_CH-1:0][DIV_W-1:0]     ch_div,
   output logic [NUM_CH-1:0][SEL_W-1:0]     ch_sel,
   output logic [NUM_CH-1:0]                ch_cken,
   output logic [NUM_CH-1:0]                ch_outen,
   output logic [NUM_CH-1:0][CNT_W-1:0]     ch_hi,
   output logic [NUM_CH-1:0][CNT_W-1:0]     ch_lo
);
   localparam int FLD_W   = ctrl_fld_w(DIV_W, SEL_W);
   localparam int SEL_LSB = DIV_W;
   localparam int CK_BIT  = DIV_W + SEL_W;
   localparam int OE_BIT  = DIV_W + SEL_W + 1;
   localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(ctrl_mask(NUM_CH, FLD_W));

   logic [DATA_W-1:0]              ctrl_q;
   logic [NUM_CH-1:0][DATA_W-1:0]  duty_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         duty_q <= '0;
      end else if (bus_we) begin
         if (bus_addr == '0) begin
            ctrl_q <= bus_wdata & CTRL_MASK;
         end
         for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(c + 1)) begin
               duty_q[c] <= bus_wdata;
            end
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) begin
         bus_rdata = ctrl_q;
      end
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(c + 1)) begin
            bus_rdata = duty_q[c];
         end
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_fld
      assign ch_div[c]   = ctrl_q[c*CH_STRIDE +: DIV_W];
      assign ch_sel[c]   = ctrl_q[c*CH_STRIDE + SEL_LSB +: SEL_W];
      assign ch_cken[c]  = ctrl_q[c*CH_STRIDE + CK_BIT];
      assign ch_outen[c] = ctrl_q[c*CH_STRIDE + OE_BIT];
      assign ch_hi[c]    = duty_q[c][DATA_W-1 -: CNT_W];
      assign ch_lo[c]    = duty_q[c][CNT_W-1:0];
   end
endmodule

// File: rtl/dpwm_prescaler.sv
`timescale 1ns/1ps
module dpwm_prescaler #(
   parameter int DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_pulse,
   input  logic [DIV_W-1:0] div,
   output logic             tick,
   output logic [DIV_W-1:0] cnt
);
   logic [DIV_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (src_pulse) begin
         if (cnt_q >= div) cnt_q <= '0;
         else              cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = !clr && src_pulse && (cnt_q >= div);
   assign cnt  = cnt_q;
endmodule

// File: rtl/dpwm_phase_gen.sv
`timescale 1ns/1ps
module dpwm_phase_gen
   import dpwm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] duty_hi,
   input  logic [CNT_W-1:0] duty_lo,
   output logic             pwm
);
   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] sh_hi_q;
   logic [CNT_W-1:0] sh_lo_q;
   logic             steady;
   logic             hi_end;
   logic             lo_end;

   assign steady = (sh_hi_q == '0) || (sh_lo_q == '0);
   assign hi_end = (cnt_q == CNT_W'(sh_hi_q - 1'b1));
   assign lo_end = (cnt_q == CNT_W'(sh_lo_q - 1'b1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_HIGH;
         cnt_q   <= '0;
         sh_hi_q <= '0;
         sh_lo_q <= '0;
      end else if (!run) begin
         phase_q <= PH_HIGH;
         cnt_q   <= '0;
         sh_hi_q <= duty_hi;
         sh_lo_q <= duty_lo;
      end else if (tick) begin
         if (steady) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
            sh_hi_q <= duty_hi;
            sh_lo_q <= duty_lo;
         end else if (phase_q == PH_HIGH) begin
            if (hi_end) begin
               phase_q <= PH_LOW;
               cnt_q   <= '0;
               sh_hi_q <= duty_hi;
               sh_lo_q <= duty_lo;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end else begin
            if (lo_end) begin
               phase_q <= PH_HIGH;
               cnt_q   <= '0;
               sh_hi_q <= duty_hi;
               sh_lo_q <= duty_lo;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign pwm = run && (sh_hi_q != '0) && ((sh_lo_q == '0) || (phase_q == PH_HIGH));
endmodule

// File: rtl/dual_phase_pwm.sv
`timescale 1ns/1ps
module dual_phase_pwm
   import dpwm_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 7,
   parameter int SEL_W  = 2,
   localparam int NUM_SRC = 1 << SEL_W,
   localparam int ADDR_W  = $clog2(NUM_CH + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_tick,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0]  pwm_out
);
   if (2 * CNT_W != DATA_W) begin : g_bad_duty
      $error("duty word must hold exactly two phase counts");
   end
   if (ctrl_fld_w(DIV_W, SEL_W) > CH_STRIDE) begin : g_bad_fld
      $error("channel control fields exceed their slice");
   end
   if (NUM_CH * CH_STRIDE > DATA_W) begin : g_bad_nch
      $error("too many channels for one control word");
   end

   logic [NUM_CH-1:0][DIV_W-1:0] div_w;
   logic [NUM_CH-1:0][SEL_W-1:0] sel_w;
   logic [NUM_CH-1:0]            cken_w;
   logic [NUM_CH-1:0]            outen_w;
   logic [NUM_CH-1:0][CNT_W-1:0] hi_w;
   logic [NUM_CH-1:0][CNT_W-1:0] lo_w;
   logic [NUM_CH-1:0]            run_w;
   logic [NUM_CH-1:0]            tick_w;
   logic [NUM_CH-1:0][DIV_W-1:0] presc_w;

   dpwm_regs #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W),
      .DIV_W(DIV_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
   ) regs_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_we   (bus_we),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .ch_div   (div_w),
      .ch_sel   (sel_w),
      .ch_cken  (cken_w),
      .ch_outen (outen_w),
      .ch_hi    (hi_w),
      .ch_lo    (lo_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic src_pulse;

      assign run_w[c] = cken_w[c] && outen_w[c];

      if (NUM_SRC == 1) begin : g_one_src
         assign src_pulse = src_tick[0];
      end else begin : g_mux_src
         assign src_pulse = src_tick[sel_w[c]];
      end

      dpwm_prescaler #(.DIV_W(DIV_W)) presc_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (!run_w[c]),
         .src_pulse(src_pulse),
         .div      (div_w[c]),
         .tick     (tick_w[c]),
         .cnt      (presc_w[c])
      );

      dpwm_phase_gen #(.CNT_W(CNT_W)) phase_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run_w[c]),
         .tick   (tick_w[c]),
         .duty_hi(hi_w[c]),
         .duty_lo(lo_w[c]),
         .pwm    (pwm_out[c])
      );
   end
endmodule

// File: rtl/dpwm_checker.sv
`timescale 1ns/1ps
module dpwm_checker #(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16,
   parameter int DIV_W  = 7,
   parameter int ADDR_W = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [NUM_CH-1:0]            run,
   input logic [NUM_CH-1:0]            tick,
   input logic [NUM_CH-1:0][DIV_W-1:0] presc,
   input logic [NUM_CH-1:0][DIV_W-1:0] div,
   input logic [NUM_CH-1:0][CNT_W-1:0] duty_hi,
   input logic [ADDR_W-1:0]            bus_addr,
   input logic                         bus_we,
   input logic [DATA_W-1:0]            bus_wdata,
   input logic [DATA_W-1:0]            bus_rdata,
   input logic [NUM_CH-1:0]            pwm_out
);
   // R2: a duty word written last cycle reads back unchanged
   p_duty_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(bus_we) && $past(bus_addr) == ADDR_W'(1) && bus_addr == ADDR_W'(1))
      |-> bus_rdata == $past(bus_wdata));

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      // R9: a gated channel is low
      p_gated_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
         !run[c] |-> !pwm_out[c]);

      // R5: the prescaler never counts past its divider
      p_presc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (run[c] && $past(run[c]) && $stable(div[c])) |-> presc[c] <= div[c]);

      // R4: while running, the output moves only after a prescaled tick
      p_move_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (run[c] && $past(run[c]) && pwm_out[c] != $past(pwm_out[c]))
         |-> $past(tick[c]));

      // R10: enabling with a non-zero high count starts high
      p_start_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(run[c]) && $past(duty_hi[c]) != '0) |-> pwm_out[c]);
   end
endmodule

bind dual_phase_pwm dpwm_checker #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .CNT_W(CNT_W),
   .DIV_W(DIV_W), .ADDR_W(ADDR_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .run      (run_w),
   .tick     (tick_w),
   .presc    (presc_w),
   .div      (div_w),
   .duty_hi  (hi_w),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .pwm_out  (pwm_out)
);

// File: tb/dual_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module dual_phase_pwm_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = 4'b0101;  // sources 0 and 2 pulse every cycle, 1 and 3 never
   logic [1:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  pwm_out;

   int n_run = 0;
   int n_fail = 0;

   typedef struct {
      logic [1:0] mask;
      logic [1:0] val;
      string      req;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   dual_phase_pwm dut_i (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .pwm_out(pwm_out)
   );

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // control slice for one channel: div [6:0], sel [8:7], clock gate 9, output gate 10
   function automatic logic [31:0] cw(input int ch, input int dv, input int sl,
                                      input bit ck, input bit oe);
      logic [15:0] s;
      s = {5'b0, oe, ck, sl[1:0], dv[6:0]};
      return 32'(s) << (16 * ch);
   endfunction

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b1; bus_wdata = d;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_addr = a;
      #1 chk(bus_rdata, exp, req);
   endtask

   task automatic push(input logic [1:0] m, input logic [1:0] v, input int n, input string req);
      for (int i = 0; i < n; i++) begin
         exp_t e;
         e.mask = m; e.val = v; e.req = req;
         exp_q.push_back(e);
      end
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
   endtask

   // monitor: compare one expected item per cycle, a quarter period after the edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            for (int c = 0; c < 2; c++) begin
               if (e.mask[c]) chk({31'b0, pwm_out[c]}, {31'b0, e.val[c]}, e.req);
            end
         end
      end
   end

   initial begin
      #(20 * 100000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (5) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: reset state
      chk({30'b0, pwm_out}, 32'h0, "R1 outputs");
      rd(2'd0, 32'h0, "R1 ctrl");
      rd(2'd1, 32'h0, "R1 dutyA");
      rd(2'd2, 32'h0, "R1 dutyB");

      // R2 / R3: readback, masking, unused address
      wr(2'd1, 32'h1234_5678);
      rd(2'd1, 32'h1234_5678, "R2 dutyA");
      wr(2'd2, 32'h9abc_def0);
      rd(2'd2, 32'h9abc_def0, "R2 dutyB");
      wr(2'd0, 32'hffff_ffff);
      rd(2'd0, 32'h07ff_07ff, "R3 ctrl mask");
      wr(2'd0, 32'h0);
      wr(2'd3, 32'hdead_beef);
      rd(2'd3, 32'h0, "R2 addr3");
      rd(2'd1, 32'h1234_5678, "R2 addr3 no effect");
      rd(2'd0, 32'h0, "R2 addr3 ctrl");

      // R4: basic waveform, high 3 low 2
      wr(2'd1, {16'd3, 16'd2});
      wr(2'd0, cw(0, 0, 0, 1, 1));
      for (int p = 0; p < 2; p++) begin
         push(2'b01, 2'b01, 3, "R4");
         push(2'b01, 2'b00, 2, "R4");
      end
      drain();
      wr(2'd0, 32'h0);

      // R5: divide by 3, high 2 low 1
      wr(2'd1, {16'd2, 16'd1});
      wr(2'd0, cw(0, 2, 0, 1, 1));
      for (int p = 0; p < 2; p++) begin
         push(2'b01, 2'b01, 6, "R5");
         push(2'b01, 2'b00, 3, "R5");
      end
      drain();
      wr(2'd0, 32'h0);

      // R6: silent source holds the phase, then switch to a live source
      wr(2'd1, {16'd2, 16'd2});
      wr(2'd0, cw(0, 0, 1, 1, 1));
      push(2'b01, 2'b01, 20, "R6 silent source");
      drain();
      wr(2'd0, cw(0, 0, 2, 1, 1));
      push(2'b01, 2'b01, 2, "R6 live source");
      push(2'b01, 2'b00, 2, "R6 live source");
      push(2'b01, 2'b01, 2, "R6 live source");
      drain();
      wr(2'd0, 32'h0);

      // R7: low count zero
      wr(2'd1, {16'd5, 16'd0});
      wr(2'd0, cw(0, 0, 0, 1, 1));
      push(2'b01, 2'b01, 20, "R7");
      drain();
      wr(2'd0, 32'h0);

      // R8: high count zero, and both zero
      wr(2'd1, {16'd0, 16'd5});
      wr(2'd0, cw(0, 0, 0, 1, 1));
      push(2'b01, 2'b00, 20, "R8");
      drain();
      wr(2'd0, 32'h0);
      wr(2'd1, 32'h0);
      wr(2'd0, cw(0, 0, 0, 1, 1));
      push(2'b01, 2'b00, 10, "R8 both zero");
      drain();
      wr(2'd0, 32'h0);

      // R9: one gate alone is not enough
      wr(2'd1, {16'd3, 16'd3});
      wr(2'd0, cw(0, 0, 0, 0, 1));
      push(2'b01, 2'b00, 10, "R9 output gate only");
      drain();
      wr(2'd0, cw(0, 0, 0, 1, 0));
      push(2'b01, 2'b00, 10, "R9 clock gate only");
      drain();
      wr(2'd0, 32'h0);

      // R10: cut mid high phase, restart from a fresh high phase
      wr(2'd1, {16'd4, 16'd4});
      wr(2'd0, cw(0, 0, 0, 1, 1));
      push(2'b01, 2'b01, 1, "R10 enable");
      wr(2'd0, 32'h0);
      push(2'b01, 2'b00, 4, "R10 disable");
      drain();
      wr(2'd0, cw(0, 0, 0, 1, 1));
      push(2'b01, 2'b01, 4, "R10 restart");
      push(2'b01, 2'b00, 4, "R10 restart");
      drain();
      wr(2'd0, 32'h0);

      // R11: new counts apply from the next boundary
      wr(2'd1, {16'd3, 16'd3});
      wr(2'd0, cw(0, 0, 0, 1, 1));
      push(2'b01, 2'b01, 3, "R11 old high");
      push(2'b01, 2'b00, 2, "R11 new low");
      push(2'b01, 2'b01, 1, "R11 new high");
      push(2'b01, 2'b00, 2, "R11 new low");
      push(2'b01, 2'b01, 1, "R11 new high");
      wr(2'd1, {16'd1, 16'd2});
      drain();
      wr(2'd0, 32'h0);

      // R12: both channels at once with different settings
      wr(2'd1, {16'd2, 16'd2});
      wr(2'd2, {16'd1, 16'd3});
      rd(2'd2, {16'd1, 16'd3}, "R12 dutyB");
      wr(2'd0, cw(0, 0, 0, 1, 1) | cw(1, 1, 2, 1, 1));
      for (int i = 0; i < 16; i++) begin
         logic [1:0] v;
         v[0] = (i % 4) < 2;
         v[1] = (i % 8) < 2;
         push(2'b11, v, 1, "R12");
      end
      drain();
      wr(2'd0, 32'h0);
      @(negedge clk);
      chk({30'b0, pwm_out}, 32'h0, "R9 all gated");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule